// File: doc/BRIEF.md
# Shared Bus Ownership Controller

This block is the master-side half of a request/grant/busy handshake with an external arbiter on a shared bus. It raises a request when the local bus engine needs the bus, or when software sets a hold bit. After the arbiter grants and the busy line goes free, it takes ownership and pulls busy low. It does not give the bus up when its own traffic ends. Instead it parks: busy stays low and the bus can be reused with no new arbitration, until the arbiter takes the grant away.

When the grant is withdrawn, ownership ends at the next bus-cycle boundary reported by the local bus engine. The busy line is then released in two steps. For one clock the block drives it high, and after that it tri-states it so the external pull-up holds it high. Grant and busy come from outside the clock domain, so each passes through a two-stage synchroniser. The reset input is applied asynchronously and removed on a clock edge.

Top module: `bus_own_ctrl`

## Requirements
- R1: With `lowpower`=0, `bus_req` equals `need_bus | req_hold` as sampled on the previous clock edge, whether or not the block owns the bus.
- R2: With `req_hold`=1 and `need_bus`=0, `bus_req` is 1 one clock later.
- R3: After `grant_in` rises, ownership (`is_master`=1, `busy_drv_oe`=1, `busy_drv_n`=0) begins once the synchronised busy line reads free. If busy is already free and a request is pending, this happens on the 4th clock edge after the grant rises, and not earlier.
- R4: While the block owns the bus and `grant_in` is low, ownership continues on every edge where `cycle_done` is 0. It ends on the first edge where the synchronised grant is low and `cycle_done` is 1.
- R5: While the grant stays high, ownership continues after the request drops (parking).
- R6: When ownership ends, the block drives `busy_drv_n`=1 with `busy_drv_oe`=1 for exactly one clock, then sets `busy_drv_oe`=0.
- R7: While `rst_n` is 0, `bus_req`, `is_master` and `busy_drv_oe` are all 0 at once, with no clock needed, and the state is bus slave.
- R8: With `lowpower`=1 and `req_hold`=0, `bus_req` is 0 one clock later. With `lowpower`=1 and `req_hold`=1, `bus_req` keeps its last value whatever `need_bus` does.
- R9: While `bus_req` is 0 and the block is not owner, `grant_in` and `busy_n_in` have no effect: `is_master` and `busy_drv_oe` stay 0.
- R10: `grant_in` and `busy_n_in` (low means busy) each pass through a two-stage synchroniser. A rising edge of `busy_n_in` while the block waits for the bus leads to ownership on the 3rd clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, removed on a clock edge |
| need_bus | input | 1 | The local bus engine needs the external bus |
| req_hold | input | 1 | Software bit that forces the request on |
| grant_in | input | 1 | Grant from the external arbiter, active high, asynchronous |
| busy_n_in | input | 1 | Sampled busy line, low = bus busy, asynchronous |
| cycle_done | input | 1 | High when no bus cycle is in flight or the current cycle ends this clock |
| lowpower | input | 1 | Stop/wait low-power indication |
| bus_req | output | 1 | Request to the arbiter, active high |
| busy_drv_n | output | 1 | Value driven onto the busy line |
| busy_drv_oe | output | 1 | Output enable for the busy line driver |
| is_master | output | 1 | The block owns the bus |

## Verification
The bench drives inputs on falling edges and counts rising edges to find when each result is due. The request follows its inputs after one edge. Ownership starts four edges after a grant rises: two for synchronisation, one to enter the pending state and one to take the bus. Ownership starts three edges after the busy line frees. Release begins one edge after the synchronised grant is low and the cycle is done. The bus is tri-stated one edge after that. Each check samples on the falling edge just after the edge where the result is due. Where a result must not appear yet, the bench also checks the edge before it, so a design that is early or late by one cycle fails.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [1:0] {
    ARB_SLAVE = 2'd0,
    ARB_PEND  = 2'd1,
    ARB_OWN   = 2'd2,
    ARB_LETGO = 2'd3
  } arb_state_t;
endpackage

// File: rtl/bus_own_sync.sv
module bus_own_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int NS = (STAGES < 1) ? 1 : STAGES;
  logic [NS-1:0] chain_q;

  generate
    if (NS == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {NS{RST_VAL}};
        else        chain_q <= {chain_q[NS-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[NS-1];
endmodule

// File: rtl/bus_own_reqgen.sv
module bus_own_reqgen (
  input  logic clk,
  input  logic rst_n,
  input  logic need_bus,
  input  logic req_hold,
  input  logic lowpower,
  output logic bus_req
);
  logic req_q, req_d;

  always_comb begin
    if (lowpower) req_d = req_hold ? req_q : 1'b0;
    else          req_d = need_bus | req_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign bus_req = req_q;

  assert_lp_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpower && !req_hold) |=> !bus_req);
  assert_lp_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpower && req_hold) |=> $stable(bus_req));
  assert_hold_forces_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowpower && req_hold) |=> bus_req);
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       grant_s,
  input  logic       busy_s,
  input  logic       cycle_done,
  output arb_state_t state
);
  arb_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_SLAVE: if (bus_req && grant_s) st_d = ARB_PEND;
      ARB_PEND: begin
        if (!bus_req || !grant_s) st_d = ARB_SLAVE;
        else if (!busy_s)         st_d = ARB_OWN;
      end
      ARB_OWN:   if (!grant_s && cycle_done) st_d = ARB_LETGO;
      ARB_LETGO: st_d = ARB_SLAVE;
      default:   st_d = ARB_SLAVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_SLAVE;
    else        st_q <= st_d;
  end

  assign state = st_q;

  assert_take_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_OWN && $past(st_q) != ARB_OWN) |-> ($past(st_q) == ARB_PEND && !$past(busy_s)));
  assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_OWN && grant_s) |=> st_q == ARB_OWN);
  assert_cycle_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_OWN && !cycle_done) |=> st_q == ARB_OWN);
  assert_letgo_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_LETGO) |=> st_q == ARB_SLAVE);
  assert_idle_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_SLAVE && !bus_req) |=> st_q == ARB_SLAVE);
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic need_bus,
  input  logic req_hold,
  input  logic grant_in,
  input  logic busy_n_in,
  input  logic cycle_done,
  input  logic lowpower,
  output logic bus_req,
  output logic busy_drv_n,
  output logic busy_drv_oe,
  output logic is_master
);
  logic       arb_rst_n;
  logic       grant_s;
  logic       busy_n_s;
  logic       busy_s;
  arb_state_t state;

  bus_own_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(arb_rst_n));

  bus_own_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_grant_sync (
    .clk(clk), .rst_n(arb_rst_n), .d(grant_in), .q(grant_s));

  bus_own_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk(clk), .rst_n(arb_rst_n), .d(busy_n_in), .q(busy_n_s));

  assign busy_s = ~busy_n_s;

  bus_own_reqgen u_req (
    .clk(clk), .rst_n(arb_rst_n), .need_bus(need_bus), .req_hold(req_hold),
    .lowpower(lowpower), .bus_req(bus_req));

  bus_own_fsm u_fsm (
    .clk(clk), .rst_n(arb_rst_n), .bus_req(bus_req), .grant_s(grant_s),
    .busy_s(busy_s), .cycle_done(cycle_done), .state(state));

  always_comb begin
    is_master   = (state == ARB_OWN);
    busy_drv_oe = (state == ARB_OWN) || (state == ARB_LETGO);
    busy_drv_n  = (state != ARB_OWN);
  end

  assert_tristate_not_owner_R6: assert property (@(posedge clk) disable iff (!arb_rst_n)
    !busy_drv_oe |-> !is_master);
  assert_release_high_R6: assert property (@(posedge clk) disable iff (!arb_rst_n)
    $fell(is_master) |-> (busy_drv_oe && busy_drv_n));
  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!bus_req && !is_master && !busy_drv_oe));
endmodule

// File: tb/sim_bus_own_ctrl.sv
module sim_bus_own_ctrl;
  logic clk = 1'b0;
  logic rst_n, need_bus, req_hold, grant_in, busy_n_in, cycle_done, lowpower;
  logic bus_req, busy_drv_n, busy_drv_oe, is_master;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_own_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .need_bus(need_bus), .req_hold(req_hold),
    .grant_in(grant_in), .busy_n_in(busy_n_in), .cycle_done(cycle_done),
    .lowpower(lowpower), .bus_req(bus_req), .busy_drv_n(busy_drv_n),
    .busy_drv_oe(busy_drv_oe), .is_master(is_master));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; need_bus = 1'b0; req_hold = 1'b0; grant_in = 1'b0;
    busy_n_in = 1'b1; cycle_done = 1'b1; lowpower = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(4);
  endtask

  task automatic t_reset_state;
    do_reset();
    chk("R7 bus_req after reset", bus_req, 1'b0);
    chk("R7 is_master after reset", is_master, 1'b0);
    chk("R7 busy_drv_oe after reset", busy_drv_oe, 1'b0);
  endtask

  task automatic t_request;
    do_reset();
    req_hold = 1'b1;
    edges(1);
    chk("R2 hold forces request", bus_req, 1'b1);
    req_hold = 1'b0; need_bus = 1'b0;
    edges(1);
    chk("R1 request drops", bus_req, 1'b0);
    need_bus = 1'b1;
    edges(1);
    chk("R1 need raises request", bus_req, 1'b1);
  endtask

  task automatic acquire_free;
    need_bus = 1'b1;
    edges(1);
    grant_in = 1'b1;
    edges(3);
    chk("R3 not owner after 3 edges", is_master, 1'b0);
    edges(1);
    chk("R3 owner after 4 edges", is_master, 1'b1);
    chk("R3 busy driven", busy_drv_oe, 1'b1);
    chk("R3 busy driven low", busy_drv_n, 1'b0);
  endtask

  task automatic t_acquire;
    do_reset();
    acquire_free();
  endtask

  task automatic t_wait_busy;
    do_reset();
    busy_n_in = 1'b0;
    need_bus = 1'b1;
    edges(3);
    grant_in = 1'b1;
    edges(10);
    chk("R3 waits while busy", is_master, 1'b0);
    busy_n_in = 1'b1;
    edges(2);
    chk("R10 not owner 2 edges after free", is_master, 1'b0);
    edges(1);
    chk("R10 owner 3 edges after free", is_master, 1'b1);
  endtask

  task automatic t_park_release;
    do_reset();
    acquire_free();
    need_bus = 1'b0;
    edges(10);
    chk("R5 request dropped", bus_req, 1'b0);
    chk("R5 still owner parked", is_master, 1'b1);
    cycle_done = 1'b0;
    grant_in = 1'b0;
    edges(8);
    chk("R4 owner while cycle in flight", is_master, 1'b1);
    cycle_done = 1'b1;
    edges(1);
    chk("R4 owner left at cycle end", is_master, 1'b0);
    chk("R6 drive enabled in release", busy_drv_oe, 1'b1);
    chk("R6 driven high in release", busy_drv_n, 1'b1);
    edges(1);
    chk("R6 tristate after one clock", busy_drv_oe, 1'b0);
  endtask

  task automatic t_lowpower;
    do_reset();
    need_bus = 1'b1;
    edges(1);
    lowpower = 1'b1;
    edges(1);
    chk("R8 request dropped in lowpower", bus_req, 1'b0);
    req_hold = 1'b1;
    edges(3);
    chk("R8 keeps last value 0", bus_req, 1'b0);
    lowpower = 1'b0;
    edges(1);
    chk("R1 request back", bus_req, 1'b1);
    lowpower = 1'b1; need_bus = 1'b0;
    edges(5);
    chk("R8 keeps last value 1", bus_req, 1'b1);
  endtask

  task automatic t_ignored;
    do_reset();
    grant_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      busy_n_in = i[0];
      edges(1);
    end
    busy_n_in = 1'b1;
    edges(4);
    chk("R9 not owner without request", is_master, 1'b0);
    chk("R9 no drive without request", busy_drv_oe, 1'b0);
  endtask

  task automatic t_reset_while_owner;
    do_reset();
    acquire_free();
    rst_n = 1'b0;
    #1;
    chk("R7 async reset clears owner", is_master, 1'b0);
    chk("R7 async reset clears request", bus_req, 1'b0);
    chk("R7 async reset clears drive", busy_drv_oe, 1'b0);
    edges(2);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; need_bus = 1'b0; req_hold = 1'b0; grant_in = 1'b0;
    busy_n_in = 1'b1; cycle_done = 1'b1; lowpower = 1'b0;
    t_reset_state();
    t_request();
    t_acquire();
    t_wait_busy();
    t_park_release();
    t_lowpower();
    t_ignored();
    t_reset_while_owner();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule